// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog that counts down from a programmable start value, one step per tick strobe. An external prescaler supplies the strobe; in the intended system one tick is 0.6 seconds. When the count reaches zero and another tick arrives, the block registers an expiry and reloads the count in the same cycle.

The first expiry sets a timeout flag. Software clears that flag by writing 1 to it, and this clearing is how software shows it is still alive. If a second expiry arrives while the flag is still set, the block sets a second-timeout flag and requests a system reset. A no-reboot gate can block that request. The first expiry can also raise a one-cycle interrupt pulse, if software has enabled it.

Software services the watchdog with a write to the reload register, and it can read the live count from that same register. The count can be frozen with a halt bit. Initial values below four are refused.

Top module: `twostage_wdt`

## Requirements
- R1: After a synchronous active-low reset, the following hold. The halt bit (bit 11 at 0x08) is 1. In the gate register at 0x0C, the no-reboot bit (bit 0) is 1 and the interrupt enable (bit 13) is 0. All status bits read 0. The initial value at 0x12 reads 0x0004 and the count at 0x00 reads 0x0004. Both `reset_req` and `smi_pulse` are 0.
- R2: While halt is 0, the count decreases by one on each cycle with `tick_en` high. A read of 0x00 returns the live count in bits 9:0, with the upper bits at 0.
- R3: While halt is 1, ticks leave the count unchanged. The halt bit reads back as last written.
- R4: Any write to 0x00, whatever its data, loads the count with the current initial value.
- R5: The initial value is bits 9:0 of 0x12 and is written per byte enable (bus_be[0] covers bits 7:0, bus_be[1] covers bits 15:8). Written bits 15:10 are dropped and read back as 0.
- R6: A write to 0x12 whose resulting 10-bit field is 0, 1, 2 or 3 is ignored, and the previous value is kept.
- R7: A tick that finds the count at 0 is an expiry. It reloads the initial value and sets bit 3 at 0x04, so the first expiry lands N+1 ticks after a reload to N.
- R8: The status bits are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R9: An expiry while bit 3 at 0x04 is set does three things: it sets bit 1 at 0x06, and, when no-reboot is 0, it also sets `reset_req` and the boot flag (bit 2 at 0x06). `reset_req` then stays high until reset, even if the status bits are cleared.
- R10: While no-reboot is 1, a second expiry sets bit 1 at 0x06 but leaves `reset_req` and the boot flag at 0.
- R11: A first expiry (bit 3 at 0x04 clear beforehand) pulses `smi_pulse` for exactly one cycle when the interrupt enable is 1, and not at all when it is 0. A second expiry never pulses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | Count step strobe from the prescaler |
| reset_req | output | 1 | Sticky system reset request |
| smi_pulse | output | 1 | One-cycle interrupt on the first expiry |

## Verification
The bench builds the block with its default parameters: a 10-bit counter and a minimum initial value of 4. It then programs small initial values, from 4 to 24, so that every expiry is reached in a few dozen ticks. For each value in that range it checks the mid-count reading, the zero state, the exact tick of the first expiry, and the second expiry under the no-reboot gate. It also sweeps every invalid initial value. The byte-enable merges, the ungated reset path with its boot flag, and the way `reset_req` holds through status clears are all driven through the register interface.

// File: rtl/wdt_pkg.sv
// Package: register offsets, bit positions and the flag bundle shared by
// the watchdog modules. Offsets are byte addresses on the register bus.
package wdt_pkg;
    localparam logic [7:0] OFF_RELOAD = 8'h00;
    localparam logic [7:0] OFF_STS1   = 8'h04;
    localparam logic [7:0] OFF_STS2   = 8'h06;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_GATE   = 8'h0C;
    localparam logic [7:0] OFF_INIT   = 8'h12;

    localparam int HALT_BIT     = 11;
    localparam int FIRST_BIT    = 3;
    localparam int SECOND_BIT   = 1;
    localparam int BOOT_BIT     = 2;
    localparam int NOREBOOT_BIT = 0;
    localparam int SMIEN_BIT    = 13;

    typedef struct packed {
        logic first;
        logic second;
        logic boot;
    } wdt_flags_t;
endpackage

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// Register file and read mux of the watchdog. It holds the halt bit, the
// gate bits (no-reboot, interrupt enable) and the initial value. It decodes
// reload writes and write-1-to-clear requests for the status flags, which
// live in wdt_stage.
// Assumes: one write per bus_wr cycle, DATA_W a multiple of 8 and
// DATA_W >= CNT_W, and a bus_addr wide enough for the highest offset.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [CNT_W-1:0]    count,
    input  wdt_flags_t          flags,
    output logic                halt,
    output logic                no_reboot,
    output logic                smi_en,
    output logic [CNT_W-1:0]    init_val,
    output logic                reload_req,
    output wdt_flags_t          clr_flags
);
    localparam int BE_W = DATA_W / 8;

    logic              halt_q, noreboot_q, smien_q;
    logic [CNT_W-1:0]  init_q;
    logic              sel_reload, sel_sts1, sel_sts2, sel_ctrl, sel_gate, sel_init;
    logic [DATA_W-1:0] init_merged;
    logic [CNT_W-1:0]  init_cand;

    // Combine old register contents with new data under the byte enables.
    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

    // Address decode for each register.
    always_comb begin
        sel_reload = (bus_addr == OFF_RELOAD[ADDR_W-1:0]);
        sel_sts1   = (bus_addr == OFF_STS1[ADDR_W-1:0]);
        sel_sts2   = (bus_addr == OFF_STS2[ADDR_W-1:0]);
        sel_ctrl   = (bus_addr == OFF_CTRL[ADDR_W-1:0]);
        sel_gate   = (bus_addr == OFF_GATE[ADDR_W-1:0]);
        sel_init   = (bus_addr == OFF_INIT[ADDR_W-1:0]);
    end

    // Candidate initial value after byte merge; upper write bits are dropped.
    always_comb begin
        init_merged = merge_bytes(DATA_W'(init_q), bus_wdata, bus_be);
        init_cand   = init_merged[CNT_W-1:0];
    end

    // Control and gate bits, each written only when its byte is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q     <= 1'b1;
            noreboot_q <= 1'b1;
            smien_q    <= 1'b0;
        end else if (bus_wr) begin
            if (sel_ctrl && bus_be[HALT_BIT/8])     halt_q     <= bus_wdata[HALT_BIT];
            if (sel_gate && bus_be[NOREBOOT_BIT/8]) noreboot_q <= bus_wdata[NOREBOOT_BIT];
            if (sel_gate && bus_be[SMIEN_BIT/8])    smien_q    <= bus_wdata[SMIEN_BIT];
        end
    end

    // Initial value register; values below the floor are refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= CNT_W'(INIT_RST);
        end else if (bus_wr && sel_init && (32'(init_cand) >= INIT_MIN)) begin
            init_q <= init_cand;
        end
    end

    // Reload strobe and write-1-to-clear requests toward the stage logic.
    always_comb begin
        reload_req       = bus_wr && sel_reload;
        clr_flags.first  = bus_wr && sel_sts1 && bus_be[FIRST_BIT/8]  && bus_wdata[FIRST_BIT];
        clr_flags.second = bus_wr && sel_sts2 && bus_be[SECOND_BIT/8] && bus_wdata[SECOND_BIT];
        clr_flags.boot   = bus_wr && sel_sts2 && bus_be[BOOT_BIT/8]   && bus_wdata[BOOT_BIT];
    end

    // Read mux: live count, status flags, control, gate and initial value.
    always_comb begin
        bus_rdata = '0;
        if (sel_reload) bus_rdata = DATA_W'(count);
        if (sel_sts1)   bus_rdata[FIRST_BIT] = flags.first;
        if (sel_sts2) begin
            bus_rdata[SECOND_BIT] = flags.second;
            bus_rdata[BOOT_BIT]   = flags.boot;
        end
        if (sel_ctrl)   bus_rdata[HALT_BIT] = halt_q;
        if (sel_gate) begin
            bus_rdata[NOREBOOT_BIT] = noreboot_q;
            bus_rdata[SMIEN_BIT]    = smien_q;
        end
        if (sel_init)   bus_rdata = DATA_W'(init_q);
    end

    assign halt      = halt_q;
    assign no_reboot = noreboot_q;
    assign smi_en    = smien_q;
    assign init_val  = init_q;

    // R6: the stored initial value never drops below the floor.
    a_r6_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
        32'(init_q) >= INIT_MIN);

    // R3: the halt bit changes only on a write to the control register.
    a_r3_halt_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel_ctrl) |=> $stable(halt_q));
endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Down-counter of the watchdog. It steps once per tick while not halted.
// A tick that finds zero is an expiry: the count reloads from the initial
// value in the same cycle and expire is high for that cycle. A reload
// request takes priority over a tick.
// Assumes: tick_en is at most one cycle wide per tick.
module wdt_counter #(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;
    logic             step;

    // A tick counts only while running and not overridden by a reload.
    always_comb begin
        step   = tick_en && !halt && !reload_req;
        expire = step && (count_q == '0);
    end

    // Count register: reload, wrap-reload on expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= CNT_W'(INIT_RST);
        else if (reload_req) count_q <= init_val;
        else if (expire)     count_q <= init_val;
        else if (step)       count_q <= count_q - 1'b1;
    end

    assign count = count_q;

    // R3: a halted counter without a reload holds its value.
    a_r3_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload_req) |=> $stable(count_q));

    // R4: a reload write lands the initial value on the next cycle.
    a_r4_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> (count_q == $past(init_val)));

    // R2: without a tick or a reload the count never moves.
    a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !reload_req) |=> $stable(count_q));
endmodule

// File: rtl/wdt_stage.sv
// Module: wdt_stage
// Two-stage expiry logic. The first expiry sets the first-timeout flag
// and may pulse the interrupt. An expiry with that flag already set sets
// the second-timeout flag and, unless no-reboot blocks it, latches the
// reset request and the boot flag. A flag being set wins over a clear
// in the same cycle.
// Assumes: expire is a single-cycle strobe, and expiries are at least
// two cycles apart.
module wdt_stage
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       no_reboot,
    input  logic       smi_en,
    input  wdt_flags_t clr_flags,
    output wdt_flags_t flags,
    output logic       reset_req,
    output logic       smi_pulse
);
    wdt_flags_t fl_q;
    logic       rst_q, smi_q;
    logic       second_hit, fire_reset;

    // Classify the current expiry as the second stage and gate the reset.
    always_comb begin
        second_hit = expire && fl_q.first;
        fire_reset = second_hit && !no_reboot;
    end

    // Status flags: set by events, cleared by write-1 requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q.first  <= expire     || (fl_q.first  && !clr_flags.first);
            fl_q.second <= second_hit || (fl_q.second && !clr_flags.second);
            fl_q.boot   <= fire_reset || (fl_q.boot   && !clr_flags.boot);
        end
    end

    // Sticky reset request and the one-cycle first-stage interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
            smi_q <= 1'b0;
        end else begin
            rst_q <= rst_q || fire_reset;
            smi_q <= expire && !fl_q.first && smi_en;
        end
    end

    assign flags     = fl_q;
    assign reset_req = rst_q;
    assign smi_pulse = smi_q;

    // R9: once raised, the reset request holds until reset.
    a_r9_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);

    // R10: a set no-reboot gate keeps a low request low.
    a_r10_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (no_reboot && !reset_req) |=> !reset_req);

    // R11: the interrupt is a single-cycle pulse.
    a_r11_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |=> !smi_pulse);

    // R9: the second flag rises only after the first one was set.
    a_r9_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.second) |-> $past(fl_q.first));
endmodule

// File: rtl/twostage_wdt.sv
// Module: twostage_wdt
// Top of the two-stage watchdog. It connects the register file, the
// down-counter and the expiry stage logic.
// Assumes: tick_en comes from an external prescaler, and bus writes are
// single-cycle strobes with combinational read data.
module twostage_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                tick_en,
    output logic                reset_req,
    output logic                smi_pulse
);
    logic             halt, no_reboot, smi_en, reload_req, expire;
    logic [CNT_W-1:0] init_val, count;
    wdt_flags_t       flags, clr_flags;

    wdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .INIT_MIN(INIT_MIN), .INIT_RST(INIT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .flags(flags),
        .halt(halt), .no_reboot(no_reboot), .smi_en(smi_en),
        .init_val(init_val), .reload_req(reload_req), .clr_flags(clr_flags)
    );

    wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
        .reload_req(reload_req), .init_val(init_val),
        .count(count), .expire(expire)
    );

    wdt_stage u_stage (
        .clk(clk), .rst_n(rst_n), .expire(expire),
        .no_reboot(no_reboot), .smi_en(smi_en), .clr_flags(clr_flags),
        .flags(flags), .reset_req(reset_req), .smi_pulse(smi_pulse)
    );
endmodule

// File: tb/sim_twostage_wdt.sv
module sim_twostage_wdt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        reset_req, smi_pulse;

    int checks = 0;
    int errors = 0;
    int smi_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    twostage_wdt u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .reset_req(reset_req), .smi_pulse(smi_pulse)
    );

    // Count interrupt pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && smi_pulse) smi_cnt++;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (k) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: bench timed out");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int base;
        do_reset();

        // R1 reset state
        rd(5'h08, v); check("R1 halt", v, 16'h0800);
        rd(5'h0C, v); check("R1 gate", v, 16'h0001);
        rd(5'h04, v); check("R1 sts1", v, 16'h0000);
        rd(5'h06, v); check("R1 sts2", v, 16'h0000);
        rd(5'h12, v); check("R1 init", v, 16'h0004);
        rd(5'h00, v); check("R1 count", v, 16'h0004);
        check("R1 reset_req", {15'b0, reset_req}, 16'h0);
        check("R1 smi", {15'b0, smi_pulse}, 16'h0);

        // R6 every invalid field value is ignored
        for (int i = 0; i < 4; i++) begin
            wr(5'h12, 16'(i), 2'b11);
            rd(5'h12, v); check("R6 invalid init", v, 16'h0004);
        end
        // R5 upper bits dropped, byte enables honoured
        wr(5'h12, 16'hFC09, 2'b11); rd(5'h12, v); check("R5 upper dropped", v, 16'h0009);
        wr(5'h12, 16'h0100, 2'b10); rd(5'h12, v); check("R5 high byte", v, 16'h0109);
        wr(5'h12, 16'h0000, 2'b10); rd(5'h12, v); check("R5 high byte clr", v, 16'h0009);
        wr(5'h12, 16'h0003, 2'b01); rd(5'h12, v); check("R6 merged invalid", v, 16'h0009);

        // R3 halted counter ignores ticks
        wr(5'h00, 16'h0000, 2'b11);
        ticks(5);
        rd(5'h00, v); check("R3 frozen", v, 16'h0009);
        wr(5'h08, 16'h0000, 2'b11); rd(5'h08, v); check("R3 halt readback", v, 16'h0000);

        // R2 R7 R10 R11 sweep over initial values, no-reboot set, interrupt on
        wr(5'h0C, 16'h2001, 2'b11);
        for (int n = 4; n <= 24; n++) begin
            wr(5'h04, 16'h0008, 2'b11);
            wr(5'h06, 16'h0006, 2'b11);
            wr(5'h12, 16'(n), 2'b11);
            wr(5'h00, 16'hABCD, 2'b11);
            base = smi_cnt;
            ticks(n / 2);
            rd(5'h00, v); check("R2 mid count", v, 16'(n - n / 2));
            ticks(n - n / 2);
            rd(5'h00, v); check("R7 zero", v, 16'h0000);
            rd(5'h04, v); check("R7 not yet", v, 16'h0000);
            ticks(1);
            rd(5'h00, v); check("R7 reloaded", v, 16'(n));
            rd(5'h04, v); check("R7 first flag", v, 16'h0008);
            check("R11 one pulse", 16'(smi_cnt - base), 16'd1);
            ticks(n + 1);
            rd(5'h06, v); check("R10 second flag only", v, 16'h0002);
            check("R10 reset blocked", {15'b0, reset_req}, 16'h0);
            check("R11 no second pulse", 16'(smi_cnt - base), 16'd1);
            rd(5'h00, v); check("R7 reload again", v, 16'(n));
        end

        // R4 reload mid-count (init is 24)
        ticks(3);
        wr(5'h00, 16'h0000, 2'b01);
        rd(5'h00, v); check("R4 reload", v, 16'd24);

        // R8 write-0 keeps, write-1 clears
        wr(5'h06, 16'h0000, 2'b11); rd(5'h06, v); check("R8 write0 keeps", v, 16'h0002);
        wr(5'h06, 16'h0002, 2'b11); rd(5'h06, v); check("R8 write1 clears", v, 16'h0000);
        wr(5'h04, 16'h0008, 2'b11); rd(5'h04, v); check("R8 sts1 clear", v, 16'h0000);

        // R3 halt while running
        wr(5'h08, 16'h0800, 2'b10);
        ticks(7);
        rd(5'h00, v); check("R3 halt running", v, 16'd24);
        wr(5'h08, 16'h0000, 2'b10);

        // R11 interrupt disabled
        wr(5'h12, 16'd6, 2'b11);
        wr(5'h0C, 16'h0001, 2'b11);
        wr(5'h00, 16'h0000, 2'b11);
        base = smi_cnt;
        ticks(7);
        rd(5'h04, v); check("R11 flag without pulse", v, 16'h0008);
        check("R11 disabled", 16'(smi_cnt - base), 16'd0);

        // R9 ungated reset path with a service clear in between
        wr(5'h04, 16'h0008, 2'b11);
        wr(5'h0C, 16'h0000, 2'b11);
        wr(5'h00, 16'h0000, 2'b11);
        ticks(7);
        wr(5'h04, 16'h0008, 2'b11);
        ticks(7);
        rd(5'h04, v); check("R9 serviced first", v, 16'h0008);
        rd(5'h06, v); check("R9 no second", v, 16'h0000);
        check("R9 no reset yet", {15'b0, reset_req}, 16'h0);
        ticks(7);
        rd(5'h06, v); check("R9 second+boot", v, 16'h0006);
        check("R9 reset raised", {15'b0, reset_req}, 16'h1);
        wr(5'h06, 16'h0006, 2'b11);
        wr(5'h04, 16'h0008, 2'b11);
        ticks(3);
        rd(5'h06, v); check("R9 flags cleared", v, 16'h0000);
        check("R9 reset sticky", {15'b0, reset_req}, 16'h1);

        do_reset();
        check("R1 reset clears req", {15'b0, reset_req}, 16'h0);
        rd(5'h12, v); check("R1 init after reset", v, 16'h0004);

        finish_run();
    end
endmodule